// File: doc/BRIEF.md
# Instrument Status Reporting Registers

This block holds the status-reporting state of a test instrument that accepts decoded commands. It has two event registers, each sticky and eight bits wide. The standard event register records power-on, command, execution, device-dependent and query errors, and operation complete. Event register 0 records instrument-specific completions: parameter calculation, print or copy output, trigger wait, measurement stop, and an error not tied to the USB link. A one-cycle pulse on an event input sets its bit. The bit then stays set until a clear-status strobe arrives, until its own register is read, or until reset. Reset stands in for a power cycle.

Each event register has an 8-bit enable mask that is written through its own strobe. The status byte is formed combinationally. Bit 5 is the OR of the enabled standard-event bits, bit 0 is the OR of the enabled event-register-0 bits, and bit 4 is the message-available input. All other bits of the status byte are zero. Read strobes from the command decoder return data on `rd_data` in the same cycle. Reading an event register also clears it on the next clock edge.

Top module: `stat_report_regs`

## Requirements
- R1: After reset the standard event register reads 0x80 (only bit 7, power-on, set). Event register 0 reads 0x00, and both enable masks are 0x00.
- R2: A pulse on an event input sets the matching implemented register bit at the next clock edge. The bit then stays set until clear-status, a read of that register, or reset.
- R3: Bits 6 and 1 of the standard event register, and bits 7, 6 and 4 of event register 0, are unimplemented. They always read 0, whatever their event inputs do.
- R4: While `std_rd` is high, `rd_data` shows the standard event register as it stands before the clock edge. While `ev0_rd` is high (and `std_rd` is low), `rd_data` shows event register 0 the same way. The register that was read is zero after the edge, except for bits that received an event in that same cycle.
- R5: `clr_status` clears both event registers at the next edge and leaves both enable masks unchanged.
- R6: An event pulse in the same cycle as `clr_status` or a read-clear wins: its bit is set after the edge.
- R7: `status_byte` bit 5 = OR(standard event & its mask). Bit 4 = `msg_avail`. Bit 0 = OR(event register 0 & its mask). Bits 7, 6, 3, 2 and 1 are 0.
- R8: While `stb_rd` is high and no event read is active, `rd_data` equals `status_byte`. Reading the status byte clears nothing.
- R9: `std_en_wr` loads `en_wdata` into the standard mask and `ev0_en_wr` loads it into the register-0 mask. Each mask holds its value until written again or reset.
- R10: Read priority is `std_rd`, then `ev0_rd`, then `stb_rd`. A read that loses priority returns nothing and clears nothing. With no read strobe, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power cycle) |
| std_evt | input | 8 | Standard event pulses, one per bit |
| ev0_evt | input | 8 | Event register 0 pulses, one per bit |
| clr_status | input | 1 | Clear-status command strobe |
| std_rd | input | 1 | Standard event register read strobe |
| ev0_rd | input | 1 | Event register 0 read strobe |
| stb_rd | input | 1 | Status byte read strobe |
| std_en_wr | input | 1 | Standard enable mask write strobe |
| ev0_en_wr | input | 1 | Event register 0 enable mask write strobe |
| en_wdata | input | 8 | Data for the enable mask writes |
| msg_avail | input | 1 | Message-available flag from the output queue |
| rd_data | output | 8 | Read data for the active read strobe |
| status_byte | output | 8 | Current status byte |

## Verification
The bench aims at the collisions. An event arriving together with a clear-status or a read-clear would be lost by a design that lets the clear win. A read that loses priority would wrongly empty its register if the clear were not tied to the winning read. Random traffic with changing masks checks that each summary bit follows its own register and mask. A swapped or unmasked summary shows up as a wrong status byte. The bench also checks that clear-status leaves the masks alone and that unimplemented bits never stick.

// File: rtl/stat_report_regs.sv
module stat_report_regs #(
  parameter int          W         = 8,
  parameter logic [W-1:0] STD_IMPL = 8'hBD,
  parameter logic [W-1:0] EV0_IMPL = 8'h2F,
  parameter int          PWR_BIT   = 7,
  parameter int          STD_SUM   = 5,
  parameter int          MAV_BIT   = 4,
  parameter int          EV0_SUM   = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] std_evt,
  input  logic [W-1:0] ev0_evt,
  input  logic         clr_status,
  input  logic         std_rd,
  input  logic         ev0_rd,
  input  logic         stb_rd,
  input  logic         std_en_wr,
  input  logic         ev0_en_wr,
  input  logic [W-1:0] en_wdata,
  input  logic         msg_avail,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] status_byte
);

  localparam logic [W-1:0] STD_RESET = STD_IMPL & (W'(1) << PWR_BIT);

  logic [W-1:0] std_q, ev0_q, std_en_q, ev0_en_q;
  logic         std_take, ev0_take, stb_take;
  logic [W-1:0] std_set, ev0_set;

  assign std_take = std_rd;
  assign ev0_take = ev0_rd & ~std_rd;
  assign stb_take = stb_rd & ~std_rd & ~ev0_rd;
  assign std_set  = std_evt & STD_IMPL;
  assign ev0_set  = ev0_evt & EV0_IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q <= STD_RESET;
      ev0_q <= '0;
    end else begin
      std_q <= ((clr_status | std_take) ? '0 : std_q) | std_set;
      ev0_q <= ((clr_status | ev0_take) ? '0 : ev0_q) | ev0_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_en_q <= '0;
      ev0_en_q <= '0;
    end else begin
      if (std_en_wr) std_en_q <= en_wdata;
      if (ev0_en_wr) ev0_en_q <= en_wdata;
    end
  end

  always_comb begin
    status_byte          = '0;
    status_byte[STD_SUM] = |(std_q & std_en_q);
    status_byte[MAV_BIT] = msg_avail;
    status_byte[EV0_SUM] = |(ev0_q & ev0_en_q);
  end

  always_comb begin
    rd_data = '0;
    if (std_take)      rd_data = std_q;
    else if (ev0_take) rd_data = ev0_q;
    else if (stb_take) rd_data = status_byte;
  end

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((std_q & ~STD_IMPL) == '0) && ((ev0_q & ~EV0_IMPL) == '0)); // R3

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_status && !std_rd) |=> ((std_q & $past(std_q)) == $past(std_q))); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    std_rd |=> ((std_q & ~$past(std_evt)) == '0)); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> ((ev0_q & $past(ev0_evt & EV0_IMPL)) == $past(ev0_evt & EV0_IMPL))); // R6

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !std_en_wr && !ev0_en_wr) |=>
      (std_en_q == $past(std_en_q)) && (ev0_en_q == $past(ev0_en_q))); // R5

  AST_STB_NOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rd && !std_rd && !ev0_rd && !clr_status) |=> ((ev0_q & $past(ev0_q)) == $past(ev0_q))); // R8

endmodule

// File: tb/stat_report_regs_bench.sv
module stat_report_regs_bench;
  logic       clk = 0, rst_n = 0;
  logic [7:0] std_evt = 0, ev0_evt = 0, en_wdata = 0;
  logic       clr_status = 0, std_rd = 0, ev0_rd = 0, stb_rd = 0;
  logic       std_en_wr = 0, ev0_en_wr = 0, msg_avail = 0;
  logic [7:0] rd_data, status_byte;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_std, m_ev0, m_sen, m_een;

  stat_report_regs u_stat_report_regs (.*);

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_stb();
    exp_stb = 8'h00;
    exp_stb[5] = |(m_std & m_sen);
    exp_stb[4] = msg_avail;
    exp_stb[0] = |(m_ev0 & m_een);
  endfunction

  function automatic logic [7:0] exp_rd();
    if (std_rd) return m_std;
    if (ev0_rd) return m_ev0;
    if (stb_rd) return exp_stb();
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    std_evt = 0; ev0_evt = 0; clr_status = 0; std_rd = 0; ev0_rd = 0;
    stb_rd = 0; std_en_wr = 0; ev0_en_wr = 0;
  endtask

  // outputs checked 1 ns after inputs settle, model updated at the edge
  task automatic step(string req);
    #1;
    check({req, " rd_data"}, rd_data, exp_rd());
    check("R7 status_byte", status_byte, exp_stb());
    @(posedge clk);
    m_std = ((clr_status || std_rd) ? 8'h00 : m_std) | (std_evt & 8'hBD);
    m_ev0 = ((clr_status || (ev0_rd && !std_rd)) ? 8'h00 : m_ev0) | (ev0_evt & 8'h2F);
    if (std_en_wr) m_sen = en_wdata;
    if (ev0_en_wr) m_een = en_wdata;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_std = 8'h80; m_ev0 = 0; m_sen = 0; m_een = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset contents
    std_rd = 1; #1 check("R1 std after reset", rd_data, 8'h80); idle();
    ev0_rd = 1; #1 check("R1 ev0 after reset", rd_data, 8'h00); idle();
    check("R1 status byte masks zero", status_byte, 8'h00);
    std_rd = 1; step("R4 power-on read");
    std_rd = 1; step("R4 read after clear");
    // R9 masks and R3 unimplemented bits
    en_wdata = 8'hFF; std_en_wr = 1; step("R9");
    en_wdata = 8'hFF; ev0_en_wr = 1; step("R9");
    std_evt = 8'h42; ev0_evt = 8'hD0; step("R3 set attempt");
    std_rd = 1; step("R3 std unused bits");
    ev0_rd = 1; step("R3 ev0 unused bits");
    // R2 sticky, R6 event wins over clear
    ev0_evt = 8'h04; step("R2");
    repeat (3) step("R2 hold");
    clr_status = 1; ev0_evt = 8'h20; std_evt = 8'h01; step("R6 with clear");
    ev0_rd = 1; step("R6 ev0 kept");
    std_rd = 1; std_evt = 8'h08; step("R6 with read");
    std_rd = 1; step("R6 std kept");
    // R10 priority: losing ev0 read keeps content
    ev0_evt = 8'h01; step("R2");
    std_rd = 1; ev0_rd = 1; stb_rd = 1; step("R10 std wins");
    ev0_rd = 1; stb_rd = 1; step("R10 ev0 kept");
    step("R10 no read zero");
    // R5 masks survive clear, R8 stb read
    std_evt = 8'h10; msg_avail = 1; step("R8");
    stb_rd = 1; step("R8 stb read");
    stb_rd = 1; step("R8 no clear");
    clr_status = 1; step("R5");
    std_evt = 8'h20; step("R5 mask kept");
    check("R5 summary with kept mask", status_byte[5], 1'b1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 4) == 0) std_evt = 8'(1 << $urandom_range(0, 7));
      if ($urandom_range(0, 4) == 0) ev0_evt = 8'(1 << $urandom_range(0, 7));
      clr_status = (r < 4);
      std_rd = (r >= 4 && r < 12) || (r == 99);
      ev0_rd = (r >= 12 && r < 20) || (r >= 97);
      stb_rd = (r >= 20 && r < 28) || (r >= 98);
      en_wdata = 8'($urandom);
      std_en_wr = ($urandom_range(0, 30) == 0);
      ev0_en_wr = ($urandom_range(0, 30) == 0);
      if ($urandom_range(0, 9) == 0) msg_avail = ~msg_avail;
      step("R4 R10 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule